// File: doc/BRIEF.md
# Performance Monitor Counter Unit

A per-core counting block for performance analysis. It provides one dedicated 32-bit cycle counter and a parameterised number of 32-bit event counters, all reached over a simple single-cycle register bus. Each event counter is bound to an event number through its own type register. Event sources arrive as a vector of one-cycle pulses indexed by event number. Two further sources are built in: a software-increment source and a clock-cycle source. A privilege-level input lets each counter ignore activity in privileged or in user mode.

Software enables counters, interrupt enables and overflow flags through per-counter bit masks. The cycle counter always sits at bit 31 of these masks and event counter k at bit k. Event counters are read and written indirectly: a counter-number register chooses which one the count and type data registers address. A single interrupt output is raised while any enabled counter has an overflow flag pending. The cycle counter can optionally advance only once every 64 clocks, and it can be frozen while a debug-active input is high.

Top module: `perf_mon_unit`

## Requirements
- R1: No counter changes while control bit 0 (global run) is 0. With it set, a counter advances only if its enable-mask bit is set.
- R2: Writing control with bit 1 set clears every event counter, and bit 2 set clears the cycle counter. Neither bit is stored; both read back as 0. An event-counter clear leaves the cycle counter untouched.
- R3: With control bit 3 set, the cycle counter advances once per 64 qualifying clocks. The prescaler is zeroed together with the cycle counter by control bit 2.
- R4: With control bit 5 set, the cycle counter holds while `dbg_active_i` is high.
- R5: Control bits 0, 3, 4 and 5 are stored and read back. Bits 15:11 read back the parameter NUM_EVT and are read-only. All other control bits read 0.
- R6: Address 1 (set) ORs written ones into the enable mask, and address 2 (clear) removes written ones. Zero bits have no effect. Both addresses read back the mask.
- R7: Addresses 3 (set) and 4 (clear) manage the interrupt-enable mask in the same way. `irq_o` is high exactly while some overflow flag has its interrupt-enable bit set.
- R8: In every mask, bit 31 is the cycle counter and bit k (k < NUM_EVT) is event counter k. Unimplemented bits cannot be set and read 0.
- R9: A counter wrapping from 0xFFFFFFFF to 0 sets its flag in the overflow register (address 5). Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R10: The select register (address 7) keeps bits 4:0. The count (address 9) and type (address 10) registers access the selected event counter. A selection at or above NUM_EVT reads 0 and ignores writes.
- R11: The type register keeps only bits 31, 30 and 7:0; bits 7:0 hold the event number. With bit 31 set, the counter ignores events while `priv_i` is 1. With bit 30 set, it ignores events while `priv_i` is 0.
- R12: Event number n counts pulses on `evt_src_i[n]`. Event 0x00 counts writes of 1 to the counter's bit at address 6. Event 0x11 counts every clock. The cycle counter is read and written at address 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from address) |
| evt_src_i | input | NUM_SRC | One-cycle event pulses, indexed by event number |
| priv_i | input | 1 | 1 while the core runs privileged |
| dbg_active_i | input | 1 | Debug-active indication |
| irq_o | output | 1 | Combined overflow interrupt |

## Verification
The case hardest to reach from the ports is the 32-bit wrap with an overflow flag raised, because counting up to it would take billions of cycles. The stimulus preloads counters to 0xFFFFFFFE or 0xFFFFFFFF through the indirect count register and the cycle register, then lets exactly one or two events through. The prescaled mode is checked over a window of 130 qualifying clocks, which lands between the second and third prescaler ticks. Every run window is bounded by two control writes, so the number of counting edges is known exactly.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned SEL_W  = 5;
  localparam int unsigned EV_W   = 8;

  localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
  localparam logic [ADDR_W-1:0] A_EN_SET   = 4'd1;
  localparam logic [ADDR_W-1:0] A_EN_CLR   = 4'd2;
  localparam logic [ADDR_W-1:0] A_IRQ_SET  = 4'd3;
  localparam logic [ADDR_W-1:0] A_IRQ_CLR  = 4'd4;
  localparam logic [ADDR_W-1:0] A_OVF      = 4'd5;
  localparam logic [ADDR_W-1:0] A_SWINC    = 4'd6;
  localparam logic [ADDR_W-1:0] A_SEL      = 4'd7;
  localparam logic [ADDR_W-1:0] A_CYC      = 4'd8;
  localparam logic [ADDR_W-1:0] A_EVT_CNT  = 4'd9;
  localparam logic [ADDR_W-1:0] A_EVT_TYPE = 4'd10;

  // control bit positions
  localparam int unsigned CB_RUN      = 0;
  localparam int unsigned CB_EVT_CLR  = 1;
  localparam int unsigned CB_CYC_CLR  = 2;
  localparam int unsigned CB_DIV64    = 3;
  localparam int unsigned CB_EXPORT   = 4;
  localparam int unsigned CB_DBG_HOLD = 5;
  localparam int unsigned CB_NUM_LSB  = 11;

  localparam int unsigned CYC_BIT = 31;
  localparam int unsigned PRE_W   = 6;

  localparam logic [EV_W-1:0] EV_SOFT   = 8'h00;
  localparam logic [EV_W-1:0] EV_CLOCKS = 8'h11;
  localparam int unsigned TB_NO_PRIV = 31;
  localparam int unsigned TB_NO_USER = 30;
endpackage

// File: rtl/pmu_evt_ctr.sv
module pmu_evt_ctr
  import pmu_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              en_i,
  input  logic              priv_i,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic              soft_inc_i,
  input  logic              clr_i,
  input  logic              cnt_wr_i,
  input  logic              type_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] count_o,
  output logic [DATA_W-1:0] type_o,
  output logic              wrap_o
);
  localparam int unsigned SRC_IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [EV_W-1:0]   ev_q;
  logic              no_priv_q, no_user_q;
  logic [DATA_W-1:0] count_q;
  logic              hit, pass, inc;

  always_comb begin
    hit = 1'b0;
    if (ev_q == EV_SOFT)               hit = soft_inc_i;
    else if (ev_q == EV_CLOCKS)        hit = 1'b1;
    else if (32'(ev_q) < NUM_SRC)      hit = src_i[ev_q[SRC_IW-1:0]];
  end

  assign pass = !(no_priv_q && priv_i) && !(no_user_q && !priv_i);
  assign inc  = run_i && en_i && hit && pass;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q      <= '0;
      no_priv_q <= 1'b0;
      no_user_q <= 1'b0;
    end else if (type_wr_i) begin
      ev_q      <= wdata_i[EV_W-1:0];
      no_priv_q <= wdata_i[TB_NO_PRIV];
      no_user_q <= wdata_i[TB_NO_USER];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       count_q <= '0;
    else if (clr_i)    count_q <= '0;
    else if (cnt_wr_i) count_q <= wdata_i;
    else if (inc)      count_q <= count_q + 1'b1;
  end

  assign wrap_o  = inc && !clr_i && !cnt_wr_i && (count_q == '1);
  assign count_o = count_q;
  assign type_o  = {no_priv_q, no_user_q, {(DATA_W-EV_W-2){1'b0}}, ev_q};

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i && !cnt_wr_i) |=> (count_q == $past(count_q))); // R1

  AST_PRIV_FILTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_priv_q && priv_i && !clr_i && !cnt_wr_i) |=> (count_q == $past(count_q))); // R11

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !cnt_wr_i) |=> (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1)); // R12
endmodule

// File: rtl/pmu_cyc_ctr.sv
module pmu_cyc_ctr
  import pmu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              en_i,
  input  logic              div_i,
  input  logic              dbg_hold_i,
  input  logic              dbg_i,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] count_o,
  output logic              wrap_o
);
  logic [PRE_W-1:0]  pre_q;
  logic [DATA_W-1:0] count_q;
  logic              qual, tick;

  assign qual = run_i && en_i && !(dbg_hold_i && dbg_i);
  assign tick = qual && (!div_i || (pre_q == '1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pre_q <= '0;
    else if (clr_i)          pre_q <= '0;
    else if (qual && div_i)  pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    count_q <= '0;
    else if (clr_i) count_q <= '0;
    else if (wr_i)  count_q <= wdata_i;
    else if (tick)  count_q <= count_q + 1'b1;
  end

  assign wrap_o  = tick && !clr_i && !wr_i && (count_q == '1);
  assign count_o = count_q;

  AST_DIV_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i && !wr_i && !clr_i) |=> (count_q == $past(count_q) || pre_q == '0)); // R3

  AST_DBG_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_hold_i && dbg_i && !wr_i && !clr_i) |=> (count_q == $past(count_q))); // R4
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int unsigned NUM_EVT = 4,
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [3:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic [NUM_SRC-1:0] evt_src_i,
  input  logic               priv_i,
  input  logic               dbg_active_i,
  output logic               irq_o
);
  localparam logic [DATA_W-1:0] IMPL_MASK =
    (DATA_W'(1) << CYC_BIT) | ((DATA_W'(1) << NUM_EVT) - 1'b1);

  logic run_q, div_q, exp_q, dbg_hold_q;
  logic [DATA_W-1:0] en_q, irq_en_q, ovf_q, wrap_vec;
  logic [SEL_W-1:0]  sel_q;
  logic              sel_ok;

  logic wr_ctrl, wr_en_set, wr_en_clr, wr_irq_set, wr_irq_clr, wr_ovf;
  logic wr_swinc, wr_sel, wr_cyc, wr_ecnt, wr_etype, evt_clr, cyc_clr;

  assign wr_ctrl    = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_en_set  = reg_we_i && (reg_addr_i == A_EN_SET);
  assign wr_en_clr  = reg_we_i && (reg_addr_i == A_EN_CLR);
  assign wr_irq_set = reg_we_i && (reg_addr_i == A_IRQ_SET);
  assign wr_irq_clr = reg_we_i && (reg_addr_i == A_IRQ_CLR);
  assign wr_ovf     = reg_we_i && (reg_addr_i == A_OVF);
  assign wr_swinc   = reg_we_i && (reg_addr_i == A_SWINC);
  assign wr_sel     = reg_we_i && (reg_addr_i == A_SEL);
  assign wr_cyc     = reg_we_i && (reg_addr_i == A_CYC);
  assign wr_ecnt    = reg_we_i && (reg_addr_i == A_EVT_CNT);
  assign wr_etype   = reg_we_i && (reg_addr_i == A_EVT_TYPE);
  assign evt_clr    = wr_ctrl && reg_wdata_i[CB_EVT_CLR];
  assign cyc_clr    = wr_ctrl && reg_wdata_i[CB_CYC_CLR];
  assign sel_ok     = 32'(sel_q) < NUM_EVT;

  // control and masks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; div_q <= 1'b0; exp_q <= 1'b0; dbg_hold_q <= 1'b0;
      sel_q <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q      <= reg_wdata_i[CB_RUN];
        div_q      <= reg_wdata_i[CB_DIV64];
        exp_q      <= reg_wdata_i[CB_EXPORT];
        dbg_hold_q <= reg_wdata_i[CB_DBG_HOLD];
      end
      if (wr_sel) sel_q <= reg_wdata_i[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      irq_en_q <= '0;
      ovf_q    <= '0;
    end else begin
      if (wr_en_set)       en_q <= en_q | (reg_wdata_i & IMPL_MASK);
      else if (wr_en_clr)  en_q <= en_q & ~reg_wdata_i;
      if (wr_irq_set)      irq_en_q <= irq_en_q | (reg_wdata_i & IMPL_MASK);
      else if (wr_irq_clr) irq_en_q <= irq_en_q & ~reg_wdata_i;
      // a new wrap wins over a same-cycle clear
      ovf_q <= (ovf_q & ~(wr_ovf ? reg_wdata_i : '0)) | wrap_vec;
    end
  end

  // event counters
  logic [DATA_W-1:0] evt_cnt  [NUM_EVT];
  logic [DATA_W-1:0] evt_type [NUM_EVT];
  logic [NUM_EVT-1:0] evt_wrap;

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
    logic hit_sel;
    assign hit_sel = sel_ok && (sel_q == SEL_W'(k));
    pmu_evt_ctr #(.NUM_SRC(NUM_SRC)) u_ctr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (run_q),
      .en_i       (en_q[k]),
      .priv_i     (priv_i),
      .src_i      (evt_src_i),
      .soft_inc_i (wr_swinc && reg_wdata_i[k]),
      .clr_i      (evt_clr),
      .cnt_wr_i   (wr_ecnt && hit_sel),
      .type_wr_i  (wr_etype && hit_sel),
      .wdata_i    (reg_wdata_i),
      .count_o    (evt_cnt[k]),
      .type_o     (evt_type[k]),
      .wrap_o     (evt_wrap[k])
    );
  end

  // cycle counter
  logic [DATA_W-1:0] cyc_cnt;
  logic              cyc_wrap;

  pmu_cyc_ctr u_cyc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_q),
    .en_i       (en_q[CYC_BIT]),
    .div_i      (div_q),
    .dbg_hold_i (dbg_hold_q),
    .dbg_i      (dbg_active_i),
    .clr_i      (cyc_clr),
    .wr_i       (wr_cyc),
    .wdata_i    (reg_wdata_i),
    .count_o    (cyc_cnt),
    .wrap_o     (cyc_wrap)
  );

  always_comb begin
    wrap_vec = '0;
    wrap_vec[NUM_EVT-1:0] = evt_wrap;
    wrap_vec[CYC_BIT] = cyc_wrap;
  end

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[CB_RUN]      = run_q;
        reg_rdata_o[CB_DIV64]    = div_q;
        reg_rdata_o[CB_EXPORT]   = exp_q;
        reg_rdata_o[CB_DBG_HOLD] = dbg_hold_q;
        reg_rdata_o[CB_NUM_LSB +: 5] = 5'(NUM_EVT);
      end
      A_EN_SET, A_EN_CLR:   reg_rdata_o = en_q;
      A_IRQ_SET, A_IRQ_CLR: reg_rdata_o = irq_en_q;
      A_OVF:                reg_rdata_o = ovf_q;
      A_SEL:                reg_rdata_o[SEL_W-1:0] = sel_q;
      A_CYC:                reg_rdata_o = cyc_cnt;
      A_EVT_CNT:
        for (int k = 0; k < NUM_EVT; k++)
          if (sel_ok && sel_q == SEL_W'(k)) reg_rdata_o = evt_cnt[k];
      A_EVT_TYPE:
        for (int k = 0; k < NUM_EVT; k++)
          if (sel_ok && sel_q == SEL_W'(k)) reg_rdata_o = evt_type[k];
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |(ovf_q & irq_en_q);

  AST_CYC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_clr |=> (cyc_cnt == '0)); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ovf |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q))); // R9

  AST_EN_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_set |=> ((en_q & $past(reg_wdata_i) & IMPL_MASK) == ($past(reg_wdata_i) & IMPL_MASK))); // R6

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en_q != '0)); // R7

  AST_UNIMPL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> ((ovf_q | en_q | irq_en_q) & ~IMPL_MASK) == '0); // R8
endmodule

// File: tb/tb_perf_mon_unit.sv
module tb_perf_mon_unit;
  localparam int unsigned NUM_EVT = 4;
  localparam int unsigned NUM_SRC = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NUM_SRC-1:0] evt_src = '0;
  logic priv = 1'b0;
  logic dbg = 1'b0;
  logic irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  perf_mon_unit #(.NUM_EVT(NUM_EVT), .NUM_SRC(NUM_SRC)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .evt_src_i(evt_src),
    .priv_i(priv), .dbg_active_i(dbg), .irq_o(irq)
  );

  typedef struct packed {
    logic [31:0] etype;
    logic        p;
    logic [4:0]  src;
    logic [3:0]  pulses;
    logic [3:0]  expect_n;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{32'h0000_0005, 1'b0, 5'd5, 4'd3, 4'd3},   // R12 plain source
    '{32'h0000_0005, 1'b0, 5'd6, 4'd3, 4'd0},   // R12 other source
    '{32'h8000_0007, 1'b1, 5'd7, 4'd4, 4'd0},   // R11 privileged excluded
    '{32'h8000_0007, 1'b0, 5'd7, 4'd4, 4'd4},   // R11 user still counted
    '{32'h4000_0007, 1'b0, 5'd7, 4'd4, 4'd0},   // R11 user excluded
    '{32'h4000_0007, 1'b1, 5'd7, 4'd4, 4'd4},   // R11 privileged counted
    '{32'h3F00_0009, 1'b0, 5'd9, 4'd2, 4'd2}    // R11 dropped bits
  };

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; reg_we = 1'b0;
    #1 d = reg_rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic pulse(input int src, input int n);
    for (int i = 0; i < n; i++) begin
      evt_src[src] = 1'b1;
      @(negedge clk);
      evt_src[src] = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // reset state
    rd(4'd0, v);  chk("R5 reset ctrl", v, 32'h0000_2000);
    rd(4'd1, v);  chk("R6 reset enable mask", v, 32'h0);
    rd(4'd5, v);  chk("R9 reset flags", v, 32'h0);
    chk("R7 reset irq", {31'd0, irq}, 32'd0);

    // control writable bits
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, v);  chk("R5 ctrl writable", v, 32'h0000_2039);
    wr(4'd0, 32'h0);
    rd(4'd0, v);  chk("R5 ctrl cleared", v, 32'h0000_2000);

    // enable set/clear
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, v);  chk("R8 enable implemented bits", v, 32'h8000_000F);
    rd(4'd2, v);  chk("R6 clear addr reads mask", v, 32'h8000_000F);
    wr(4'd2, 32'h8000_0001);
    rd(4'd1, v);  chk("R6 clear ones only", v, 32'h0000_000E);
    wr(4'd1, 32'h0);
    rd(4'd1, v);  chk("R6 zero set no effect", v, 32'h0000_000E);
    wr(4'd2, 32'hFFFF_FFFF);

    // vector table on counter 0
    foreach (VECS[i]) begin
      wr(4'd7, 32'd0);
      wr(4'd10, VECS[i].etype);
      wr(4'd9, 32'd0);
      wr(4'd1, 32'h1);
      priv = VECS[i].p;
      wr(4'd0, 32'h1);
      pulse(int'(VECS[i].src), int'(VECS[i].pulses));
      wr(4'd0, 32'h0);
      rd(4'd9, v);  chk($sformatf("R11/R12 vector %0d", i), v, 32'(VECS[i].expect_n));
    end
    priv = 1'b0;
    rd(4'd10, v); chk("R11 type masked", v, 32'h0000_0009);
    wr(4'd10, 32'hFFFF_FFFF);
    rd(4'd10, v); chk("R11 type kept bits", v, 32'hC000_00FF);

    // clock-cycle event on counter 1
    wr(4'd7, 32'd1); wr(4'd10, 32'h11); wr(4'd9, 32'd0); wr(4'd1, 32'h2);
    wr(4'd0, 32'h1);
    repeat (9) @(negedge clk);
    wr(4'd0, 32'h0);
    rd(4'd9, v);  chk("R12 clock event counts 10", v, 32'd10);

    // software increment on counter 2, counter 0 type 0x05 unaffected
    wr(4'd7, 32'd0); wr(4'd10, 32'h5); wr(4'd9, 32'd0);
    wr(4'd7, 32'd2); wr(4'd10, 32'h0); wr(4'd9, 32'd0); wr(4'd1, 32'h4);
    wr(4'd0, 32'h1);
    wr(4'd6, 32'h5);
    wr(4'd6, 32'h5);
    wr(4'd0, 32'h0);
    rd(4'd9, v);  chk("R12 soft increment", v, 32'd2);
    wr(4'd6, 32'h4);
    rd(4'd9, v);  chk("R1 soft increment while stopped", v, 32'd2);
    wr(4'd7, 32'd0);
    rd(4'd9, v);  chk("R12 soft increment ignored by other event", v, 32'd0);

    // global gating and per-counter disable
    pulse(5, 3);
    rd(4'd9, v);  chk("R1 stopped ignores pulses", v, 32'd0);
    wr(4'd2, 32'h1);
    wr(4'd0, 32'h1);
    pulse(5, 3);
    wr(4'd0, 32'h0);
    rd(4'd9, v);  chk("R1 disabled counter holds", v, 32'd0);

    // select register
    wr(4'd7, 32'hFFFF_FFE3);
    rd(4'd7, v);  chk("R10 select low bits", v, 32'd3);
    rd(4'd9, v);  chk("R10 counter 3 initial", v, 32'd0);
    wr(4'd7, 32'd7);
    rd(4'd9, v);  chk("R10 out of range reads 0", v, 32'd0);
    wr(4'd9, 32'h1234);
    wr(4'd10, 32'h55);
    rd(4'd10, v); chk("R10 out of range type 0", v, 32'd0);
    wr(4'd7, 32'd3);
    rd(4'd9, v);  chk("R10 out of range write ignored", v, 32'd0);
    wr(4'd7, 32'd2);
    rd(4'd9, v);  chk("R10 counter 2 intact", v, 32'd2);

    // cycle counter
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd8, 32'd100);
    wr(4'd1, 32'h8000_0000);
    wr(4'd0, 32'h1);
    repeat (9) @(negedge clk);
    wr(4'd0, 32'h0);
    rd(4'd8, v);  chk("R8 cycle counter via bit 31", v, 32'd110);
    dbg = 1'b1;
    wr(4'd0, 32'h21);
    repeat (9) @(negedge clk);
    wr(4'd0, 32'h20);
    dbg = 1'b0;
    rd(4'd8, v);  chk("R4 debug hold", v, 32'd110);
    wr(4'd0, 32'h0D);
    rd(4'd0, v);  chk("R2 clear bits read zero", v, 32'h0000_2009);
    repeat (129) @(negedge clk);
    wr(4'd0, 32'h0);
    rd(4'd8, v);  chk("R3 divide by 64", v, 32'd2);

    // event counter clear
    wr(4'd0, 32'h2);
    wr(4'd7, 32'd2);
    rd(4'd9, v);  chk("R2 event clear counter 2", v, 32'd0);
    wr(4'd7, 32'd1);
    rd(4'd9, v);  chk("R2 event clear counter 1", v, 32'd0);
    rd(4'd8, v);  chk("R2 cycle untouched", v, 32'd2);

    // overflow and interrupt
    wr(4'd7, 32'd0); wr(4'd10, 32'h5); wr(4'd9, 32'hFFFF_FFFE);
    wr(4'd1, 32'h1); wr(4'd3, 32'h1);
    wr(4'd0, 32'h1);
    pulse(5, 2);
    wr(4'd0, 32'h0);
    rd(4'd9, v);  chk("R9 counter wrapped", v, 32'd0);
    rd(4'd5, v);  chk("R9 flag bit 0", v, 32'h1);
    chk("R7 irq raised", {31'd0, irq}, 32'd1);
    wr(4'd5, 32'h0);
    rd(4'd5, v);  chk("R9 zero write keeps flag", v, 32'h1);
    wr(4'd5, 32'h1);
    rd(4'd5, v);  chk("R9 flag cleared", v, 32'h0);
    chk("R7 irq dropped", {31'd0, irq}, 32'd0);

    wr(4'd8, 32'hFFFF_FFFF);
    wr(4'd4, 32'h1);
    wr(4'd0, 32'h1);
    wr(4'd0, 32'h0);
    rd(4'd8, v);  chk("R9 cycle wrapped", v, 32'd0);
    rd(4'd5, v);  chk("R8 cycle flag bit 31", v, 32'h8000_0000);
    chk("R7 masked flag no irq", {31'd0, irq}, 32'd0);
    wr(4'd3, 32'h8000_0000);
    rd(4'd4, v);  chk("R7 irq mask readback", v, 32'h8000_0000);
    chk("R7 irq on cycle flag", {31'd0, irq}, 32'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule